// File: doc/BRIEF.md
# Interrupt-Enable and Single-Step Trap Controller

This block sits at the instruction boundary of a processor pipeline and decides, each time an instruction retires, whether control must divert to a handler. Two diversions are possible: an external maskable interrupt, gated by an interrupt-enable flag, and a single-step debug trap, driven by a trap flag. The interrupt-enable flag is turned on and off by decoded set-interrupt and clear-interrupt instruction strobes. The trap flag is written through a small write port.

With the trap flag on, one instruction retires and a trap with vector 1 follows. The first handler instruction is shielded from trapping by an internal handler mask. The mask drops on the exception-return strobe, so the next user instruction traps again. This repeats until software writes the trap flag to 0. When a trap and an interrupt meet at the same boundary, the trap is taken first. Both decisions leave the block as registered one-cycle pulses.

Top module: `step_trap_ctrl`

## Requirements
- R1: After reset both flags are 0, and take_irq, take_exc and exc_vec are all 0.
- R2: A cycle with sti_op high sets the interrupt-enable flag from the next cycle on. A cycle with cli_op high clears it from the next cycle on. When both are high in one cycle, the flag ends up 0.
- R3: When retire and irq_req are high in a cycle and the interrupt-enable flag is 1 (and no trap is taken at that boundary), take_irq is 1 in the following cycle for exactly one cycle.
- R4: While the interrupt-enable flag is 0, irq_req has no effect: take_irq stays 0 even when irq_req and retire are high.
- R5: When retire is high, the trap flag is 1 and the handler mask is clear, take_exc is 1 in the following cycle for exactly one cycle, with exc_vec equal to 1 (the TRAP_VEC default).
- R6: Taking either a trap or an interrupt sets the handler mask. While the mask is set, no trap is taken. An exc_ret pulse clears the mask, and the next retire with the trap flag still 1 traps again.
- R7: A cycle with tf_we high loads tf_wdata into the trap flag from the next cycle on. Once the flag is 0, retiring instructions raise no trap.
- R8: When a trap and an enabled interrupt request are both due at one boundary, only take_exc pulses. The interrupt can be taken at a later boundary.
- R9: Without retire, neither take_irq nor take_exc pulses. exc_vec is 0 whenever take_exc is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_req | input | 1 | External maskable interrupt request |
| retire | input | 1 | Instruction-boundary strobe, one per retired instruction |
| sti_op | input | 1 | Set-interrupt instruction strobe |
| cli_op | input | 1 | Clear-interrupt instruction strobe |
| tf_we | input | 1 | Trap-flag write enable |
| tf_wdata | input | 1 | Trap-flag write value |
| exc_ret | input | 1 | Handler-return strobe; clears the handler mask |
| take_irq | output | 1 | One-cycle pulse: divert to the external interrupt |
| take_exc | output | 1 | One-cycle pulse: divert to the internal exception |
| exc_vec | output | VEC_W | Exception vector, valid with take_exc, 0 otherwise |

## Verification
A single-step trap and an enabled interrupt request can fall due at the same retire boundary. The bench provokes this by turning on both the interrupt-enable and trap flags, then pulsing retire with irq_req held high. It expects take_exc with vector 1 and take_irq low in the following cycle. At the next retire, with the handler mask now blocking the trap, it expects the still-pending interrupt to be taken and no second trap.

// File: rtl/stc_pkg.sv
package stc_pkg;
   // decision made at one instruction boundary
   typedef enum logic [1:0] {
      TK_NONE = 2'd0,
      TK_IRQ  = 2'd1,
      TK_TRAP = 2'd2
   } take_e;
endpackage

// File: rtl/stc_irq_sync.sv
module stc_irq_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      assert (STAGES >= 0 && STAGES <= 4)
         else $error("stc_irq_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d;
            else chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/stc_flags.sv
module stc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic sti_op,
   input  logic cli_op,
   input  logic tf_we,
   input  logic tf_wdata,
   output logic ie,
   output logic tf
);
   logic ie_q, tf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
         tf_q <= 1'b0;
      end else begin
         if (cli_op)      ie_q <= 1'b0;
         else if (sti_op) ie_q <= 1'b1;
         if (tf_we)       tf_q <= tf_wdata;
      end
   end

   assign ie = ie_q;
   assign tf = tf_q;

   p_cli_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cli_op |=> !ie);
   p_sti_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sti_op && !cli_op) |=> ie);
   p_ie_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sti_op && !cli_op) |=> $stable(ie));
   p_tf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tf_we |=> $stable(tf));
endmodule

// File: rtl/stc_arb.sv
module stc_arb
   import stc_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int TRAP_VEC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire,
   input  logic             irq,
   input  logic             ie,
   input  logic             tf,
   input  logic             exc_ret,
   output logic             take_irq,
   output logic             take_exc,
   output logic [VEC_W-1:0] exc_vec
);
   localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(TRAP_VEC);

   take_e kind;
   logic  mask_q, irq_q, exc_q;

   // trap is examined before the external request
   always_comb begin
      kind = TK_NONE;
      if (retire) begin
         if (tf && !mask_q)  kind = TK_TRAP;
         else if (ie && irq) kind = TK_IRQ;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
         irq_q  <= 1'b0;
         exc_q  <= 1'b0;
      end else begin
         if (kind != TK_NONE) mask_q <= 1'b1;
         else if (exc_ret)    mask_q <= 1'b0;
         irq_q <= (kind == TK_IRQ);
         exc_q <= (kind == TK_TRAP);
      end
   end

   assign take_irq = irq_q;
   assign take_exc = exc_q;
   assign exc_vec  = exc_q ? VEC_VAL : '0;

   p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |=> !take_irq);
   p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq && !(retire && irq && ie) |=> !take_irq);
   p_exc_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_exc |=> !take_exc);
   p_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_exc |-> (exc_vec == VEC_VAL));
   p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !exc_ret) |=> !take_exc);
   p_one_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_irq && take_exc));
   p_need_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !retire |=> (!take_irq && !take_exc));
   p_vec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !take_exc |-> (exc_vec == '0));
endmodule

// File: rtl/step_trap_ctrl.sv
module step_trap_ctrl #(
   parameter int VEC_W    = 8,
   parameter int TRAP_VEC = 1,
   parameter int IRQ_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic             retire,
   input  logic             sti_op,
   input  logic             cli_op,
   input  logic             tf_we,
   input  logic             tf_wdata,
   input  logic             exc_ret,
   output logic             take_irq,
   output logic             take_exc,
   output logic [VEC_W-1:0] exc_vec
);
   initial begin
      assert (VEC_W >= 1 && VEC_W <= 16)
         else $error("step_trap_ctrl: VEC_W out of range");
      assert (TRAP_VEC >= 0 && TRAP_VEC < (1 << VEC_W))
         else $error("step_trap_ctrl: TRAP_VEC does not fit VEC_W");
   end

   logic irq_s, ie, tf;

   stc_irq_sync #(.STAGES(IRQ_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_req), .q(irq_s)
   );

   stc_flags u_flags (
      .clk(clk), .rst_n(rst_n), .sti_op(sti_op), .cli_op(cli_op),
      .tf_we(tf_we), .tf_wdata(tf_wdata), .ie(ie), .tf(tf)
   );

   stc_arb #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_arb (
      .clk(clk), .rst_n(rst_n), .retire(retire), .irq(irq_s),
      .ie(ie), .tf(tf), .exc_ret(exc_ret),
      .take_irq(take_irq), .take_exc(take_exc), .exc_vec(exc_vec)
   );

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!take_irq && !take_exc));
endmodule

// File: tb/step_trap_ctrl_tb.sv
`timescale 1ns/1ps
module step_trap_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_req = 0, retire = 0, sti_op = 0, cli_op = 0;
   logic tf_we = 0, tf_wdata = 0, exc_ret = 0;
   logic take_irq, take_exc;
   logic [7:0] exc_vec;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   step_trap_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .retire(retire),
      .sti_op(sti_op), .cli_op(cli_op), .tf_we(tf_we), .tf_wdata(tf_wdata),
      .exc_ret(exc_ret), .take_irq(take_irq), .take_exc(take_exc),
      .exc_vec(exc_vec)
   );

   // drive one cycle at a negedge; outputs of that edge visible at next negedge
   task automatic cyc(input logic r, input logic irq, input logic s,
                      input logic c, input logic we, input logic wd,
                      input logic er);
      retire = r; irq_req = irq; sti_op = s; cli_op = c;
      tf_we = we; tf_wdata = wd; exc_ret = er;
      @(negedge clk);
      retire = 0; irq_req = 0; sti_op = 0; cli_op = 0;
      tf_we = 0; tf_wdata = 0; exc_ret = 0;
   endtask

   task automatic chk(input string tag, input logic ei, input logic ee,
                      input logic [7:0] ev);
      total++;
      if (take_irq !== ei || take_exc !== ee || exc_vec !== ev) begin
         bad++;
         $display("FAIL %s: irq=%b exc=%b vec=%0d expected irq=%b exc=%b vec=%0d",
                  tag, take_irq, take_exc, exc_vec, ei, ee, ev);
      end
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R4 irq ignored after reset", 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R1 trap flag clear after reset", 0, 0, 0);
   endtask

   task automatic t_enable();
      cyc(0, 0, 1, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0, 0, 0);
      chk("R9 irq without retire", 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R3 R2 irq taken after sti", 1, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk("R3 irq pulse one cycle", 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R9 retire without irq", 0, 0, 0);
   endtask

   task automatic t_disable();
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R2 R4 irq ignored after cli", 0, 0, 0);
      cyc(0, 0, 1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R2 sti and cli together leave flag 0", 0, 0, 0);
   endtask

   task automatic t_step();
      cyc(0, 0, 0, 0, 1, 1, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R5 trap after retire", 0, 1, 8'd1);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R6 handler instruction not trapped", 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk("R5 exc pulse one cycle", 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R6 trap repeats after return", 0, 1, 8'd1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 1, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R7 no trap after flag cleared", 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R7 still no trap", 0, 0, 0);
   endtask

   task automatic t_collide();
      cyc(0, 0, 1, 0, 1, 1, 0);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R8 trap wins over irq", 0, 1, 8'd1);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R8 irq taken at later boundary", 1, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R6 mask still blocks trap", 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R6 trap resumes after return", 0, 1, 8'd1);
      cyc(0, 0, 0, 1, 1, 0, 1);
      cyc(1, 1, 0, 0, 0, 0, 0);
      chk("R9 quiet after both flags cleared", 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_disable();
      t_step();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule